// File: doc/BRIEF.md
# Block Address Translation Matcher

This block turns a 32-bit effective address into a physical address using a small bank of block-mapping entries. Each entry holds an upper word (the effective block base, a block-length field and two privilege-valid bits) and a lower word (the physical block base and a two-bit protection code). Half of the entries serve instruction fetches, the other half serve data accesses, and a lookup only scans the half that matches its access class.

A lookup presents the address, the access class, the privilege mode and a write flag. One cycle later the block reports whether an entry hit, the access permission for that hit and the translated address. When several entries hit, the one with the lowest index decides. The entries are loaded one word at a time through a write port and all start invalid after reset.

Top module: `blkx_top`

## Requirements
- R1: After reset every entry is invalid (both words zero), so every lookup misses until an entry is written.
- R2: A write with `wr_en` high loads `wr_data` into entry `wr_idx`, upper word when `wr_upper` is 1 and lower word otherwise. A lookup issued in the same cycle as a write still sees the old contents; lookups from the next cycle on see the new contents.
- R3: Instruction lookups (`lk_instr`=1) consider only entries 0..N_ENT/2-1; data lookups consider only entries N_ENT/2..N_ENT-1.
- R4: Upper-word bit 0 enables an entry for user-mode lookups and bit 1 for supervisor-mode lookups; an entry whose bit for the current mode is clear never hits.
- R5: The compare mask is 0x0001FFFF ORed with the upper word's bits 12:2 shifted left by 15 (so block-length bit k lands on address bit k+15); the smallest block is 128 KiB.
- R6: An entry hits when the lookup address and the upper word agree on every bit outside the mask.
- R7: On a hit the physical address takes the lookup address bits inside the mask and the lower word's bits outside the mask.
- R8: Lower-word bits 1:0 give the protection: 00 yields status 0 (denied); 01 and 11 yield status 1 (read-only) for reads and status 0 for writes; 10 yields status 2 (read-write). Status 3 never appears.
- R9: When more than one entry in the searched half hits, the lowest-indexed one supplies status and physical address.
- R10: On a miss `rs_hit` is 0, `rs_status` is 0 and `rs_paddr` is 0.
- R11: `rs_valid` is high exactly in the cycle after a cycle with `lk_valid` high, and the result fields belong to that lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write one entry word |
| wr_idx | input | 3 | Entry index to write |
| wr_upper | input | 1 | 1 selects the upper word, 0 the lower word |
| wr_data | input | 32 | Word to write |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_addr | input | 32 | Effective address |
| lk_instr | input | 1 | 1 for instruction fetch, 0 for data access |
| lk_user | input | 1 | 1 for user mode, 0 for supervisor mode |
| lk_write | input | 1 | 1 for a store |
| rs_valid | output | 1 | Result valid (one cycle after the lookup) |
| rs_hit | output | 1 | An entry hit |
| rs_status | output | 2 | 0 denied, 1 read-only, 2 read-write |
| rs_paddr | output | 32 | Translated physical address, 0 on a miss |

## Verification
An entry update and a lookup that depends on it can arrive in the same cycle; the bench provokes this by writing an entry's words while issuing a lookup that the new contents would hit, and judges that the result reflects the old contents while an identical lookup one cycle later reflects the new ones. The random phase keeps rewriting entries while lookups stream, so this overlap recurs with many field values, and the bench's model always computes the expected result before applying that cycle's write. Overlapping entries within one half also stress the lowest-index rule against the permission decode in the same lookup.

// File: rtl/blkx_pkg.sv
package blkx_pkg;

  localparam int unsigned WORD_W = 32;
  localparam logic [WORD_W-1:0] MIN_MASK = 32'h0001_FFFF;

  typedef enum logic [1:0] {
    ST_DENY = 2'd0,
    ST_RO   = 2'd1,
    ST_RW   = 2'd2
  } blkx_status_e;

  typedef struct packed {
    logic [WORD_W-1:0] upper;
    logic [WORD_W-1:0] lower;
  } blkx_entry_t;

  // Compare mask: length field kept in place (bits 12:2) and moved up by 15.
  function automatic logic [WORD_W-1:0] blkx_mask(input logic [WORD_W-1:0] upper);
    return ((upper & 32'h0000_1FFC) << 15) | MIN_MASK;
  endfunction

  function automatic logic blkx_enabled(input logic [WORD_W-1:0] upper, input logic user);
    return user ? upper[0] : upper[1];
  endfunction

  function automatic logic blkx_match(input logic [WORD_W-1:0] upper,
                                      input logic [WORD_W-1:0] addr);
    logic [WORD_W-1:0] m;
    m = blkx_mask(upper);
    return (addr & ~m) == (upper & ~m);
  endfunction

  function automatic logic [WORD_W-1:0] blkx_phys(input logic [WORD_W-1:0] upper,
                                                  input logic [WORD_W-1:0] lower,
                                                  input logic [WORD_W-1:0] addr);
    logic [WORD_W-1:0] m;
    m = blkx_mask(upper);
    return (addr & m) | (lower & ~m);
  endfunction

  function automatic blkx_status_e blkx_perm(input logic [1:0] prot, input logic write);
    case (prot)
      2'b00:   return ST_DENY;
      2'b10:   return ST_RW;
      default: return write ? ST_DENY : ST_RO;
    endcase
  endfunction

endpackage

// File: rtl/blkx_regs.sv
module blkx_regs
  import blkx_pkg::*;
#(
  parameter int unsigned N_ENT = 8,
  localparam int unsigned IDX_W = $clog2(N_ENT)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic                    wr_upper,
  input  logic [WORD_W-1:0]       wr_data,
  output blkx_entry_t [N_ENT-1:0] entries
);

  for (genvar i = 0; i < N_ENT; i++) begin : g_ent
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        entries[i] <= '0;
      end else if (sel) begin
        if (wr_upper) entries[i].upper <= wr_data;
        else          entries[i].lower <= wr_data;
      end
    end
  end

endmodule

// File: rtl/blkx_entry.sv
module blkx_entry
  import blkx_pkg::*;
(
  input  blkx_entry_t       ent,
  input  logic [WORD_W-1:0] addr,
  input  logic              user,
  input  logic              write,
  output logic              hit,
  output blkx_status_e      status,
  output logic [WORD_W-1:0] paddr
);

  logic [1:0] prot;
  assign prot   = ent.lower[1:0];
  assign hit    = blkx_enabled(ent.upper, user) && blkx_match(ent.upper, addr);
  assign status = blkx_perm(prot, write);
  assign paddr  = blkx_phys(ent.upper, ent.lower, addr);

endmodule

// File: rtl/blkx_pick.sv
module blkx_pick #(
  parameter int unsigned N_ENT = 8
) (
  input  logic [N_ENT-1:0] req,
  output logic [N_ENT-1:0] grant
);

  always_comb begin
    logic seen;
    seen  = 1'b0;
    grant = '0;
    for (int i = 0; i < N_ENT; i++) begin
      grant[i] = req[i] && !seen;
      seen     = seen || req[i];
    end
  end

endmodule

// File: rtl/blkx_top.sv
module blkx_top
  import blkx_pkg::*;
#(
  parameter int unsigned N_ENT = 8,
  localparam int unsigned IDX_W = $clog2(N_ENT),
  localparam int unsigned HALF  = N_ENT / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_upper,
  input  logic [31:0]      wr_data,
  input  logic             lk_valid,
  input  logic [31:0]      lk_addr,
  input  logic             lk_instr,
  input  logic             lk_user,
  input  logic             lk_write,
  output logic             rs_valid,
  output logic             rs_hit,
  output logic [1:0]       rs_status,
  output logic [31:0]      rs_paddr
);

  blkx_entry_t [N_ENT-1:0] entries;
  logic [N_ENT-1:0]        raw_hit;
  logic [N_ENT-1:0]        in_group;
  logic [N_ENT-1:0]        hit_vec;
  logic [N_ENT-1:0]        grant;
  blkx_status_e            ent_status [N_ENT];
  logic [WORD_W-1:0]       ent_paddr  [N_ENT];
  logic                    any_hit;
  logic [1:0]              sel_status;
  logic [WORD_W-1:0]       sel_paddr;

  blkx_regs #(.N_ENT(N_ENT)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_upper (wr_upper),
    .wr_data  (wr_data),
    .entries  (entries)
  );

  for (genvar i = 0; i < N_ENT; i++) begin : g_match
    blkx_entry u_ent (
      .ent    (entries[i]),
      .addr   (lk_addr),
      .user   (lk_user),
      .write  (lk_write),
      .hit    (raw_hit[i]),
      .status (ent_status[i]),
      .paddr  (ent_paddr[i])
    );
    if (i < HALF) begin : g_ifetch
      assign in_group[i] = lk_instr;
    end else begin : g_data
      assign in_group[i] = !lk_instr;
    end
  end

  assign hit_vec = raw_hit & in_group;

  blkx_pick #(.N_ENT(N_ENT)) u_pick (
    .req   (hit_vec),
    .grant (grant)
  );

  assign any_hit = |hit_vec;

  always_comb begin
    sel_status = '0;
    sel_paddr  = '0;
    for (int i = 0; i < N_ENT; i++) begin
      sel_status = sel_status | ({2{grant[i]}} & ent_status[i]);
      sel_paddr  = sel_paddr  | ({WORD_W{grant[i]}} & ent_paddr[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rs_valid  <= 1'b0;
      rs_hit    <= 1'b0;
      rs_status <= '0;
      rs_paddr  <= '0;
    end else begin
      rs_valid <= lk_valid;
      if (lk_valid) begin
        rs_hit    <= any_hit;
        rs_status <= sel_status;
        rs_paddr  <= sel_paddr;
      end
    end
  end

endmodule

// File: rtl/blkx_chk.sv
module blkx_chk #(
  parameter int unsigned N_ENT = 8,
  localparam int unsigned HALF = N_ENT / 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             lk_valid,
  input logic             lk_instr,
  input logic             lk_write,
  input logic [N_ENT-1:0] grant,
  input logic [N_ENT-1:0] hit_vec,
  input logic             rs_valid,
  input logic             rs_hit,
  input logic [1:0]       rs_status,
  input logic [31:0]      rs_paddr
);

  logic written;
  always_ff @(posedge clk) begin
    if (!rst_n) written <= 1'b0;
    else if (wr_en) written <= 1'b1;
  end

  p_reset_miss_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !written) |=> !rs_hit);

  p_group_instr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lk_instr |-> (hit_vec[N_ENT-1:HALF] == '0));

  p_group_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_instr |-> (hit_vec[HALF-1:0] == '0));

  p_no_code3_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid |-> (rs_status != 2'd3));

  p_store_not_ro_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_write) |=> (rs_status != 2'd1));

  p_single_winner_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && ((hit_vec != '0) == (grant != '0)));

  p_miss_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_hit) |-> (rs_status == 2'd0 && rs_paddr == 32'd0));

  p_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rs_valid);

  p_no_spurious_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rs_valid);

endmodule

bind blkx_top blkx_chk #(.N_ENT(N_ENT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .lk_valid  (lk_valid),
  .lk_instr  (lk_instr),
  .lk_write  (lk_write),
  .grant     (grant),
  .hit_vec   (hit_vec),
  .rs_valid  (rs_valid),
  .rs_hit    (rs_hit),
  .rs_status (rs_status),
  .rs_paddr  (rs_paddr)
);

// File: tb/test_blkx_top.sv
module test_blkx_top;

  localparam int CLK_PERIOD = 10;
  localparam int NE = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, wr_upper;
  logic [2:0]  wr_idx;
  logic [31:0] wr_data;
  logic        lk_valid, lk_instr, lk_user, lk_write;
  logic [31:0] lk_addr;
  logic        rs_valid, rs_hit;
  logic [1:0]  rs_status;
  logic [31:0] rs_paddr;

  int n_vec = 0;
  int n_bad = 0;

  logic [31:0] m_up [NE];
  logic [31:0] m_lo [NE];

  always #(CLK_PERIOD/2) clk = ~clk;

  blkx_top i_blkx_top (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_upper(wr_upper), .wr_data(wr_data),
    .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_instr(lk_instr),
    .lk_user(lk_user), .lk_write(lk_write),
    .rs_valid(rs_valid), .rs_hit(rs_hit), .rs_status(rs_status), .rs_paddr(rs_paddr)
  );

  // Mask built bit by bit: low 17 bits always, bit b (17..27) from upper bit b-15.
  function automatic logic [31:0] ref_mask(input logic [31:0] up);
    logic [31:0] m;
    for (int b = 0; b < 32; b++) begin
      if (b < 17) m[b] = 1'b1;
      else if (b <= 27) m[b] = up[b-15];
      else m[b] = 1'b0;
    end
    return m;
  endfunction

  task automatic ref_lookup(input logic [31:0] a, input logic ins, input logic usr,
                            input logic wr, output logic h, output logic [1:0] st,
                            output logic [31:0] pa);
    h = 1'b0; st = 2'd0; pa = 32'd0;
    for (int k = 0; k < NE; k++) begin
      logic [31:0] m;
      logic en;
      if (h) continue;
      if (ins && k >= NE/2) continue;
      if (!ins && k < NE/2) continue;
      en = usr ? m_up[k][0] : m_up[k][1];
      if (!en) continue;
      m = ref_mask(m_up[k]);
      if (((a ^ m_up[k]) & ~m) != 32'd0) continue;
      h  = 1'b1;
      pa = (a & m) | (m_lo[k] & ~m);
      case (m_lo[k][1:0])
        2'b00: st = 2'd0;
        2'b10: st = 2'd2;
        default: st = wr ? 2'd0 : 2'd1;
      endcase
    end
  endtask

  task automatic fail_line(input string tag, input string what,
                           input logic [31:0] act, input logic [31:0] exp);
    n_bad++;
    $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
  endtask

  // One cycle: drive at negedge, expected from the model before this cycle's write.
  task automatic step(input logic we, input logic [2:0] idx, input logic up,
                      input logic [31:0] d, input logic lv, input logic [31:0] a,
                      input logic ins, input logic usr, input logic wr, input string tag);
    logic eh; logic [1:0] es; logic [31:0] ep;
    wr_en = we; wr_idx = idx; wr_upper = up; wr_data = d;
    lk_valid = lv; lk_addr = a; lk_instr = ins; lk_user = usr; lk_write = wr;
    ref_lookup(a, ins, usr, wr, eh, es, ep);
    if (we) begin
      if (up) m_up[idx] = d; else m_lo[idx] = d;
    end
    @(negedge clk);
    n_vec++;
    if (rs_valid !== lv) fail_line("R11", "valid", 32'(rs_valid), 32'(lv));
    else if (lv) begin
      if (rs_hit !== eh) fail_line(tag, "hit", 32'(rs_hit), 32'(eh));
      else if (rs_status !== es) fail_line(tag, "status", 32'(rs_status), 32'(es));
      else if (rs_paddr !== ep) fail_line(tag, "paddr", rs_paddr, ep);
    end
  endtask

  task automatic wr(input logic [2:0] idx, input logic [31:0] u, input logic [31:0] l);
    step(1'b1, idx, 1'b1, u, 1'b0, 32'd0, 1'b0, 1'b0, 1'b0, "R2");
    step(1'b1, idx, 1'b0, l, 1'b0, 32'd0, 1'b0, 1'b0, 1'b0, "R2");
  endtask

  task automatic lk(input logic [31:0] a, input logic ins, input logic usr,
                    input logic w, input string tag);
    step(1'b0, 3'd0, 1'b0, 32'd0, 1'b1, a, ins, usr, w, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fail_line("WATCHDOG", "timeout", 32'd0, 32'd1);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    for (int k = 0; k < NE; k++) begin m_up[k] = '0; m_lo[k] = '0; end
    rst_n = 1'b0;
    wr_en = 0; wr_idx = 0; wr_upper = 0; wr_data = 0;
    lk_valid = 0; lk_addr = 0; lk_instr = 0; lk_user = 0; lk_write = 0;
    repeat (3) @(negedge clk);
    n_vec++;
    if (rs_valid !== 1'b0) fail_line("R11", "reset valid", 32'(rs_valid), 32'd0);
    rst_n = 1'b1;

    // R1: zeroed entries miss in every mode
    lk(32'h0000_0000, 1'b1, 1'b0, 1'b0, "R1");
    lk(32'h0000_0000, 1'b0, 1'b1, 1'b0, "R1");
    // R10: miss reports zeros
    lk(32'hDEAD_BEEF, 1'b0, 1'b0, 1'b1, "R10");

    // R2: lookup in the same cycle as the write sees old contents
    step(1'b1, 3'd4, 1'b1, 32'h1000_0003, 1'b1, 32'h1000_1234, 1'b0, 1'b0, 1'b0, "R2");
    step(1'b1, 3'd4, 1'b0, 32'h8000_0002, 1'b1, 32'h1000_1234, 1'b0, 1'b0, 1'b0, "R2");
    lk(32'h1000_1234, 1'b0, 1'b0, 1'b0, "R2");
    // R7: offset kept, base replaced
    lk(32'h1001_FFFC, 1'b0, 1'b1, 1'b1, "R7");
    // R6: just outside the 128 KiB block
    lk(32'h1002_0000, 1'b0, 1'b0, 1'b0, "R6");
    // R3: instruction lookup ignores data entry 4
    lk(32'h1000_1234, 1'b1, 1'b0, 1'b0, "R3");

    // R4: supervisor-only entry in the instruction half
    wr(3'd0, 32'h2000_0002, 32'h4000_0002);
    lk(32'h2000_0010, 1'b1, 1'b0, 1'b0, "R4");
    lk(32'h2000_0010, 1'b1, 1'b1, 1'b0, "R4");
    // user-only
    wr(3'd1, 32'h3000_0001, 32'h5000_0002);
    lk(32'h3000_0010, 1'b1, 1'b1, 1'b0, "R4");
    lk(32'h3000_0010, 1'b1, 1'b0, 1'b0, "R4");

    // R5: largest block (all length bits set) covers 256 MiB
    wr(3'd5, 32'h6000_1FFF, 32'hA000_0002);
    lk(32'h6FFF_FFF0, 1'b0, 1'b0, 1'b0, "R5");
    lk(32'h7000_0000, 1'b0, 1'b0, 1'b0, "R5");
    // R5: a single length bit (bit 2 -> address bit 17) doubles the block
    wr(3'd6, 32'h8000_0007, 32'hC000_0002);
    lk(32'h8003_0000, 1'b0, 1'b0, 1'b0, "R5");
    lk(32'h8004_0000, 1'b0, 1'b0, 1'b0, "R5");

    // R8: each protection code, read and write
    for (int p = 0; p < 4; p++) begin
      wr(3'd7, 32'h9000_0003, 32'hE000_0000 | 32'(p));
      lk(32'h9000_0100, 1'b0, 1'b0, 1'b0, "R8");
      lk(32'h9000_0100, 1'b0, 1'b0, 1'b1, "R8");
    end

    // R9: entries 5 and 7 both cover 0x6...; 5 must win; then 6 overlapping 7
    wr(3'd7, 32'h6000_0003, 32'hF000_0001);
    lk(32'h6000_0040, 1'b0, 1'b0, 1'b1, "R9");
    wr(3'd6, 32'h9000_0003, 32'hD000_0001);
    wr(3'd7, 32'h9000_0003, 32'hE000_0002);
    lk(32'h9000_0040, 1'b0, 1'b0, 1'b0, "R9");
    // R11: idle cycle gives no result
    step(1'b0, 3'd0, 1'b0, 32'd0, 1'b0, 32'd0, 1'b0, 1'b0, 1'b0, "R11");

    // Random phase with concurrent writes and lookups
    for (int n = 0; n < 3000; n++) begin
      logic [2:0] ri, ti; logic [31:0] d, a, m;
      logic we;
      ri = 3'($urandom_range(0, 7));
      ti = 3'($urandom_range(0, 7));
      we = ($urandom_range(0, 3) == 0);
      d  = $urandom();
      if ($urandom_range(0, 1) == 1) d = (d & 32'hFFFF_FFFC) | 32'($urandom_range(1, 3));
      m  = ref_mask(m_up[ti]);
      a  = $urandom();
      if ($urandom_range(0, 3) != 0) a = (m_up[ti] & ~m) | (a & m);
      step(we, ri, 1'($urandom_range(0, 1)), d, 1'($urandom_range(0, 7) != 0), a,
           (ti < 4), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), "R9");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule